// File: doc/BRIEF.md
# Instruction Operand and Immediate Decoder

This block turns a 32-bit fixed-length instruction word, plus the selector codes and opcode flags that an upstream opcode-table lookup has already produced, into the operand requests an execution stage consumes. It names up to three general-register reads, two special-register reads, one general-register write and one special-register write. It also builds a 64-bit immediate and gives the record bit, the overflow-enable bit and the link bit. Every request has its own valid flag, so the issue logic never has to decode the selectors again.

Instruction bits are numbered with bit 0 as the most significant, so instruction bit k sits at `insnWord[31-k]`. A control module reads the selectors and a few instruction bits and produces a small struct of strobes. A datapath module extracts the fields, shifts and extends the immediate, and applies the strobes. An output stage that a parameter selects either registers the result for one cycle (the default) or passes it through.

Top module: `operand_decoder`

## Requirements
- R1: With `src1Sel`=1 (plain RA), read port 1 is valid with index RA (bits 11–15) even when RA is 0. With `src2Sel`=1 (RB), read port 2 is valid with bits 16–20. With `src3Sel`=1 (RS), read port 3 is valid with bits 6–10. Selector 0 leaves the port not valid.
- R2: With `src1Sel`=2 (RA or zero), read port 1 is not valid when RA is 0. Otherwise it is valid with index RA.
- R3: Immediates from bits 16–31. `src2Sel`=3 zero-extends the field. `src2Sel`=4 sign-extends it from 16 bits. `src2Sel`=5 zero-extends it and shifts it left by 16. `src2Sel`=6 shifts it left by 16 and sign-extends from 32 bits.
- R4: Branch offsets are shifted left by 2 and zero-extended. `src2Sel`=7 takes bits 6–29. `src2Sel`=8 and `src2Sel`=9 take bits 16–29. The two lowest instruction bits do not appear.
- R5: `src2Sel`=10 gives all ones. `src2Sel`=11 gives a 6-bit shift amount, with bit 30 above bits 16–20. `src2Sel`=12 gives bits 16–20 alone.
- R6: With `src2Sel`=2, the immediate and read port 2 are not valid and special read 2 is valid. Special read 2 targets number 9 (count) when instruction bit 21 is set and number 8 (link) otherwise.
- R7: With `isSprMove` set, special read 1 is valid with the 10-bit field in bits 11–20. With `isCondBranch` set and instruction bit 8 clear, special read 1 is valid with number 9. With bit 8 set it is not valid.
- R8: `dstSel`=3 makes the special write valid (number from bits 11–20) and the general write not valid. `dstSel`=0 makes neither valid. `dstSel`=1 makes the general write valid with bits 6–10, and `dstSel`=2 does the same with bits 11–15.
- R9: The record and overflow-enable outputs are always valid out of reset. The record bit is 0 for `recSel`=0 or 3, 1 for `recSel`=1, and instruction bit 31 for `recSel`=2. The overflow-enable bit is instruction bit 21.
- R10: With `hasLink` set, `linkBit` equals instruction bit 31; with it clear, `linkBit` is 0. `src2Sel` codes 13–15 raise `illegal` and leave the immediate not valid.
- R11: With `REG_OUT`=1, outputs follow the inputs sampled at the previous rising clock edge. While `rst` is high, every valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous reset, active high |
| insnWord | input | 32 | Raw instruction word |
| src1Sel | input | 2 | First-source selector |
| src2Sel | input | 4 | Second-source / immediate selector |
| src3Sel | input | 1 | Third-source selector |
| dstSel | input | 2 | Destination selector |
| recSel | input | 2 | Record-bit selector |
| isCondBranch | input | 1 | Opcode is a conditional branch |
| isSprMove | input | 1 | Opcode moves to or from a special register |
| hasLink | input | 1 | Opcode carries a link bit |
| rdReg1Vld | output | 1 | Read port 1 valid |
| rdReg1Idx | output | 5 | Read port 1 index |
| rdReg2Vld | output | 1 | Read port 2 valid |
| rdReg2Idx | output | 5 | Read port 2 index |
| rdReg3Vld | output | 1 | Read port 3 valid |
| rdReg3Idx | output | 5 | Read port 3 index |
| sprRd1Vld | output | 1 | Special read 1 valid |
| sprRd1Num | output | 10 | Special read 1 number |
| sprRd2Vld | output | 1 | Special read 2 valid |
| sprRd2Num | output | 10 | Special read 2 number |
| wrRegVld | output | 1 | General write valid |
| wrRegIdx | output | 5 | General write index |
| wrSprVld | output | 1 | Special write valid |
| wrSprNum | output | 10 | Special write number |
| immVld | output | 1 | Immediate valid |
| immData | output | 64 | Immediate value |
| recVld | output | 1 | Record bit valid |
| recBit | output | 1 | Record bit |
| ovfVld | output | 1 | Overflow-enable valid |
| ovfBit | output | 1 | Overflow-enable bit |
| linkBit | output | 1 | Link bit |
| illegal | output | 1 | Unrecognised immediate selector |

## Verification
The block keeps no state beyond the output register, so a bad strobe or a bad field slice shows at the ports one cycle after the inputs that exposed it. It never takes longer. A wrong bit position shows as a shifted index or immediate, and the test patterns use asymmetric field values so that a swap or an off-by-one slice is visible. A lost or extra strobe shows as a valid flag in the wrong state. Two flags raised together that should exclude each other also show this way: special read 2 with the immediate, or both writes.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  parameter int INSN_W    = 32;
  parameter int XLEN      = 64;
  parameter int GPR_IDX_W = 5;
  parameter int SPR_NUM_W = 10;

  typedef enum logic [1:0] {
    SRC1_NONE = 2'd0, SRC1_RA = 2'd1, SRC1_RAZ = 2'd2, SRC1_RSVD = 2'd3
  } src1Sel_e;

  typedef enum logic [3:0] {
    SRC2_NONE    = 4'd0,  SRC2_RB     = 4'd1,  SRC2_SPR    = 4'd2,
    SRC2_U16     = 4'd3,  SRC2_S16    = 4'd4,  SRC2_U16HI  = 4'd5,
    SRC2_S16HI   = 4'd6,  SRC2_LONGBR = 4'd7,  SRC2_CONDBR = 4'd8,
    SRC2_DISP    = 4'd9,  SRC2_MINUS1 = 4'd10, SRC2_SH6    = 4'd11,
    SRC2_SH5     = 4'd12
  } src2Sel_e;

  typedef enum logic {
    SRC3_NONE = 1'b0, SRC3_RS = 1'b1
  } src3Sel_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_RT = 2'd1, DST_RA = 2'd2, DST_SPR = 2'd3
  } dstSel_e;

  typedef enum logic [1:0] {
    REC_NONE = 2'd0, REC_ONE = 2'd1, REC_RC = 2'd2, REC_RSVD = 2'd3
  } recSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     rd1En;
    logic     rd2En;
    logic     rd3En;
    logic     spr1En;
    logic     spr1UseCtr;
    logic     spr2En;
    logic     spr2UseCtr;
    logic     wrRegEn;
    logic     wrRegUseRa;
    logic     wrSprEn;
    logic     immEn;
    src2Sel_e immKind;
    recSel_e  recMode;
    logic     linkEn;
    logic     illegal;
  } strobe_t;

  typedef struct packed {
    logic                 rd1Vld;
    logic [GPR_IDX_W-1:0] rd1Idx;
    logic                 rd2Vld;
    logic [GPR_IDX_W-1:0] rd2Idx;
    logic                 rd3Vld;
    logic [GPR_IDX_W-1:0] rd3Idx;
    logic                 spr1Vld;
    logic [SPR_NUM_W-1:0] spr1Num;
    logic                 spr2Vld;
    logic [SPR_NUM_W-1:0] spr2Num;
    logic                 wrRegVld;
    logic [GPR_IDX_W-1:0] wrRegIdx;
    logic                 wrSprVld;
    logic [SPR_NUM_W-1:0] wrSprNum;
    logic                 immVld;
    logic [XLEN-1:0]      immData;
    logic                 recVld;
    logic                 recBit;
    logic                 ovfVld;
    logic                 ovfBit;
    logic                 linkBit;
    logic                 illegal;
  } decOut_t;
endpackage

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
(
  input  logic [1:0]           src1Sel,
  input  logic [3:0]           src2Sel,
  input  logic                 src3Sel,
  input  logic [1:0]           dstSel,
  input  logic [1:0]           recSel,
  input  logic                 isCondBranch,
  input  logic                 isSprMove,
  input  logic                 hasLink,
  input  logic [GPR_IDX_W-1:0] raField,
  input  logic                 boCtrBit,
  input  logic                 xoHighBit,
  output strobe_t              strobe
);
  src1Sel_e s1;
  src2Sel_e s2;
  dstSel_e  dst;

  assign s1  = src1Sel_e'(src1Sel);
  assign s2  = src2Sel_e'(src2Sel);
  assign dst = dstSel_e'(dstSel);

  always_comb begin
    strobe = '0;
    // first source
    unique case (s1)
      SRC1_RA:  strobe.rd1En = 1'b1;
      SRC1_RAZ: strobe.rd1En = (raField != '0);
      default:  strobe.rd1En = 1'b0;
    endcase
    // second source or immediate
    case (s2)
      SRC2_NONE: ;
      SRC2_RB:   strobe.rd2En = 1'b1;
      SRC2_SPR: begin
        strobe.spr2En     = 1'b1;
        strobe.spr2UseCtr = xoHighBit;
      end
      SRC2_U16, SRC2_S16, SRC2_U16HI, SRC2_S16HI, SRC2_LONGBR,
      SRC2_CONDBR, SRC2_DISP, SRC2_MINUS1, SRC2_SH6, SRC2_SH5: begin
        strobe.immEn   = 1'b1;
        strobe.immKind = s2;
      end
      default:   strobe.illegal = 1'b1;
    endcase
    // third source
    strobe.rd3En = (src3Sel_e'(src3Sel) == SRC3_RS);
    // special read 1: a move takes precedence over a branch count
    if (isSprMove) begin
      strobe.spr1En = 1'b1;
    end else if (isCondBranch && !boCtrBit) begin
      strobe.spr1En     = 1'b1;
      strobe.spr1UseCtr = 1'b1;
    end
    // destination
    unique case (dst)
      DST_RT:  strobe.wrRegEn = 1'b1;
      DST_RA: begin
        strobe.wrRegEn    = 1'b1;
        strobe.wrRegUseRa = 1'b1;
      end
      DST_SPR: strobe.wrSprEn = 1'b1;
      default: ;
    endcase
    strobe.recMode = recSel_e'(recSel);
    strobe.linkEn  = hasLink;
  end
endmodule

// File: rtl/opdec_datapath.sv
module opdec_datapath
  import opdec_pkg::*;
#(
  parameter int CTR_NUM = 9,
  parameter int LR_NUM  = 8
) (
  input  logic [INSN_W-1:0] insnWord,
  input  strobe_t           strobe,
  output decOut_t           dOut
);
  // instruction bit k (bit 0 = MSB) lives at vector index INSN_W-1-k
  localparam int RT_LO   = INSN_W - 1 - 10;
  localparam int RA_LO   = INSN_W - 1 - 15;
  localparam int RB_LO   = INSN_W - 1 - 20;
  localparam int HALF_W  = 16;
  localparam int LI_W    = 24;
  localparam int LI_LO   = INSN_W - 1 - 29;
  localparam int BD_W    = 14;
  localparam int SPR_LO  = INSN_W - 1 - 20;
  localparam int B30     = INSN_W - 1 - 30;
  localparam int B31     = INSN_W - 1 - 31;
  localparam int B21     = INSN_W - 1 - 21;
  localparam int SH6_W   = GPR_IDX_W + 1;

  logic [GPR_IDX_W-1:0] rtF, raF, rbF;
  logic [SPR_NUM_W-1:0] sprF;
  logic [HALF_W-1:0]    halfF;
  logic [LI_W-1:0]      liF;
  logic [BD_W-1:0]      bdF;
  logic [SH6_W-1:0]     sh6F;
  logic [XLEN-1:0]      immMux;
  logic                 unusedPrimary;

  assign rtF   = insnWord[RT_LO +: GPR_IDX_W];
  assign raF   = insnWord[RA_LO +: GPR_IDX_W];
  assign rbF   = insnWord[RB_LO +: GPR_IDX_W];
  assign sprF  = insnWord[SPR_LO +: SPR_NUM_W];
  assign halfF = insnWord[0 +: HALF_W];
  assign liF   = insnWord[LI_LO +: LI_W];
  assign bdF   = insnWord[LI_LO +: BD_W];
  assign sh6F  = {insnWord[B30], rbF};
  assign unusedPrimary = ^insnWord[INSN_W-1:RT_LO+GPR_IDX_W];

  always_comb begin
    unique case (strobe.immKind)
      SRC2_U16:    immMux = {{(XLEN-HALF_W){1'b0}}, halfF};
      SRC2_S16:    immMux = {{(XLEN-HALF_W){halfF[HALF_W-1]}}, halfF};
      SRC2_U16HI:  immMux = {{(XLEN-2*HALF_W){1'b0}}, halfF, {HALF_W{1'b0}}};
      SRC2_S16HI:  immMux = {{(XLEN-2*HALF_W){halfF[HALF_W-1]}}, halfF, {HALF_W{1'b0}}};
      SRC2_LONGBR: immMux = {{(XLEN-LI_W-2){1'b0}}, liF, 2'b00};
      SRC2_CONDBR,
      SRC2_DISP:   immMux = {{(XLEN-BD_W-2){1'b0}}, bdF, 2'b00};
      SRC2_MINUS1: immMux = '1;
      SRC2_SH6:    immMux = {{(XLEN-SH6_W){1'b0}}, sh6F};
      SRC2_SH5:    immMux = {{(XLEN-GPR_IDX_W){1'b0}}, rbF};
      default:     immMux = '0;
    endcase
  end

  always_comb begin
    dOut = '0;
    dOut.rd1Vld   = strobe.rd1En;
    dOut.rd1Idx   = strobe.rd1En ? raF : '0;
    dOut.rd2Vld   = strobe.rd2En;
    dOut.rd2Idx   = strobe.rd2En ? rbF : '0;
    dOut.rd3Vld   = strobe.rd3En;
    dOut.rd3Idx   = strobe.rd3En ? rtF : '0;
    dOut.spr1Vld  = strobe.spr1En;
    if (strobe.spr1En)
      dOut.spr1Num = strobe.spr1UseCtr ? SPR_NUM_W'(CTR_NUM) : sprF;
    dOut.spr2Vld  = strobe.spr2En;
    if (strobe.spr2En)
      dOut.spr2Num = strobe.spr2UseCtr ? SPR_NUM_W'(CTR_NUM) : SPR_NUM_W'(LR_NUM);
    dOut.wrRegVld = strobe.wrRegEn;
    if (strobe.wrRegEn)
      dOut.wrRegIdx = strobe.wrRegUseRa ? raF : rtF;
    dOut.wrSprVld = strobe.wrSprEn;
    dOut.wrSprNum = strobe.wrSprEn ? sprF : '0;
    dOut.immVld   = strobe.immEn;
    dOut.immData  = strobe.immEn ? immMux : '0;
    dOut.recVld   = 1'b1;
    unique case (strobe.recMode)
      REC_ONE: dOut.recBit = 1'b1;
      REC_RC:  dOut.recBit = insnWord[B31];
      default: dOut.recBit = 1'b0;
    endcase
    dOut.ovfVld   = 1'b1;
    dOut.ovfBit   = insnWord[B21];
    dOut.linkBit  = strobe.linkEn & insnWord[B31];
    dOut.illegal  = strobe.illegal;
  end
endmodule

// File: rtl/opdec_outstage.sv
module opdec_outstage
  import opdec_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  decOut_t dIn,
  output decOut_t dOut
);
  generate
    if (REG_OUT != 0) begin : gReg
      always_ff @(posedge clk) begin
        if (rst) dOut <= '0;
        else     dOut <= dIn;
      end
    end else begin : gPass
      logic unusedClkRst;
      assign unusedClkRst = clk ^ rst;
      assign dOut = dIn;
    end
  endgenerate
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opdec_pkg::*;
#(
  parameter int REG_OUT = 1,
  parameter int CTR_NUM = 9,
  parameter int LR_NUM  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSN_W-1:0]    insnWord,
  input  logic [1:0]           src1Sel,
  input  logic [3:0]           src2Sel,
  input  logic                 src3Sel,
  input  logic [1:0]           dstSel,
  input  logic [1:0]           recSel,
  input  logic                 isCondBranch,
  input  logic                 isSprMove,
  input  logic                 hasLink,
  output logic                 rdReg1Vld,
  output logic [GPR_IDX_W-1:0] rdReg1Idx,
  output logic                 rdReg2Vld,
  output logic [GPR_IDX_W-1:0] rdReg2Idx,
  output logic                 rdReg3Vld,
  output logic [GPR_IDX_W-1:0] rdReg3Idx,
  output logic                 sprRd1Vld,
  output logic [SPR_NUM_W-1:0] sprRd1Num,
  output logic                 sprRd2Vld,
  output logic [SPR_NUM_W-1:0] sprRd2Num,
  output logic                 wrRegVld,
  output logic [GPR_IDX_W-1:0] wrRegIdx,
  output logic                 wrSprVld,
  output logic [SPR_NUM_W-1:0] wrSprNum,
  output logic                 immVld,
  output logic [XLEN-1:0]      immData,
  output logic                 recVld,
  output logic                 recBit,
  output logic                 ovfVld,
  output logic                 ovfBit,
  output logic                 linkBit,
  output logic                 illegal
);
  localparam int RA_LO = INSN_W - 1 - 15;
  localparam int B8    = INSN_W - 1 - 8;
  localparam int B21   = INSN_W - 1 - 21;

  strobe_t strobe;
  decOut_t comb, outQ;

  opdec_ctrl uCtrl (
    .src1Sel      (src1Sel),
    .src2Sel      (src2Sel),
    .src3Sel      (src3Sel),
    .dstSel       (dstSel),
    .recSel       (recSel),
    .isCondBranch (isCondBranch),
    .isSprMove    (isSprMove),
    .hasLink      (hasLink),
    .raField      (insnWord[RA_LO +: GPR_IDX_W]),
    .boCtrBit     (insnWord[B8]),
    .xoHighBit    (insnWord[B21]),
    .strobe       (strobe)
  );

  opdec_datapath #(.CTR_NUM(CTR_NUM), .LR_NUM(LR_NUM)) uDp (
    .insnWord (insnWord),
    .strobe   (strobe),
    .dOut     (comb)
  );

  opdec_outstage #(.REG_OUT(REG_OUT)) uOut (
    .clk  (clk),
    .rst  (rst),
    .dIn  (comb),
    .dOut (outQ)
  );

  assign rdReg1Vld = outQ.rd1Vld;
  assign rdReg1Idx = outQ.rd1Idx;
  assign rdReg2Vld = outQ.rd2Vld;
  assign rdReg2Idx = outQ.rd2Idx;
  assign rdReg3Vld = outQ.rd3Vld;
  assign rdReg3Idx = outQ.rd3Idx;
  assign sprRd1Vld = outQ.spr1Vld;
  assign sprRd1Num = outQ.spr1Num;
  assign sprRd2Vld = outQ.spr2Vld;
  assign sprRd2Num = outQ.spr2Num;
  assign wrRegVld  = outQ.wrRegVld;
  assign wrRegIdx  = outQ.wrRegIdx;
  assign wrSprVld  = outQ.wrSprVld;
  assign wrSprNum  = outQ.wrSprNum;
  assign immVld    = outQ.immVld;
  assign immData   = outQ.immData;
  assign recVld    = outQ.recVld;
  assign recBit    = outQ.recBit;
  assign ovfVld    = outQ.ovfVld;
  assign ovfBit    = outQ.ovfBit;
  assign linkBit   = outQ.linkBit;
  assign illegal   = outQ.illegal;

  generate
    if (REG_OUT != 0) begin : gChk
      logic primed;
      always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
      end

      AST_RAZ_HOLE: assert property (@(posedge clk) disable iff (rst)
        primed && $past(src1Sel == 2'd2 && insnWord[RA_LO +: GPR_IDX_W] == '0) |-> !rdReg1Vld); // R2
      AST_MINUS_ONE: assert property (@(posedge clk) disable iff (rst)
        primed && $past(src2Sel == 4'd10) |-> immVld && (&immData)); // R5
      AST_SPR2_ALONE: assert property (@(posedge clk) disable iff (rst)
        sprRd2Vld |-> !immVld && !rdReg2Vld); // R6
      AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wrRegVld && wrSprVld)); // R8
      AST_REC_LIVE: assert property (@(posedge clk) disable iff (rst)
        primed |-> recVld && ovfVld); // R9
      AST_ILLEGAL_NOIMM: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !immVld); // R10
      AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> !immVld && !recVld && !rdReg1Vld && !wrRegVld); // R11
    end
  endgenerate
endmodule

// File: tb/sim_operand_decoder.sv
module sim_operand_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insnWord;
  logic [1:0]  src1Sel, dstSel, recSel;
  logic [3:0]  src2Sel;
  logic        src3Sel, isCondBranch, isSprMove, hasLink;
  logic        rdReg1Vld, rdReg2Vld, rdReg3Vld, sprRd1Vld, sprRd2Vld;
  logic [4:0]  rdReg1Idx, rdReg2Idx, rdReg3Idx, wrRegIdx;
  logic [9:0]  sprRd1Num, sprRd2Num, wrSprNum;
  logic        wrRegVld, wrSprVld, immVld, recVld, recBit, ovfVld, ovfBit;
  logic        linkBit, illegal;
  logic [63:0] immData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  operand_decoder u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(input logic [4:0] rt, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic [10:0] tail);
    return {6'd0, rt, ra, rb, tail};
  endfunction

  task automatic clearIn();
    insnWord = '0; src1Sel = '0; src2Sel = '0; src3Sel = 1'b0;
    dstSel = '0; recSel = '0; isCondBranch = 1'b0; isSprMove = 1'b0; hasLink = 1'b0;
  endtask

  // inputs are set at a falling edge; outputs sampled one falling edge later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    clearIn();
    src1Sel = 2'd1; src2Sel = 4'd3; dstSel = 2'd1;
    repeat (2) @(negedge clk);
    check("R11 reset rd1", rdReg1Vld, 0);
    check("R11 reset imm", immVld, 0);
    check("R11 reset rec", recVld, 0);
    check("R11 reset wr", wrRegVld, 0);
    rst = 1'b0;
    clearIn();
    step();
  endtask

  task automatic testGprPorts();
    clearIn();
    insnWord = fmt(5'd5, 5'd7, 5'd9, 11'd0);
    src1Sel = 2'd1; src2Sel = 4'd1; src3Sel = 1'b1;
    step();
    check("R1 rd1 vld", rdReg1Vld, 1); check("R1 rd1 idx", rdReg1Idx, 7);
    check("R1 rd2 vld", rdReg2Vld, 1); check("R1 rd2 idx", rdReg2Idx, 9);
    check("R1 rd3 vld", rdReg3Vld, 1); check("R1 rd3 idx", rdReg3Idx, 5);
    check("R1 no imm", immVld, 0);
    insnWord = fmt(5'd5, 5'd0, 5'd9, 11'd0);
    step();
    check("R1 plain RA zero vld", rdReg1Vld, 1); check("R1 plain RA zero idx", rdReg1Idx, 0);
    src1Sel = 2'd0; src2Sel = 4'd0; src3Sel = 1'b0;
    step();
    check("R1 none rd1", rdReg1Vld, 0); check("R1 none rd2", rdReg2Vld, 0);
    check("R1 none rd3", rdReg3Vld, 0);
  endtask

  task automatic testRaz();
    clearIn();
    src1Sel = 2'd2;
    insnWord = fmt(5'd31, 5'd0, 5'd1, 11'd0);
    step();
    check("R2 ra zero", rdReg1Vld, 0);
    insnWord = fmt(5'd0, 5'd3, 5'd1, 11'd0);
    step();
    check("R2 ra nonzero vld", rdReg1Vld, 1); check("R2 ra nonzero idx", rdReg1Idx, 3);
  endtask

  task automatic testImm();
    clearIn();
    insnWord = {16'hFC00, 16'h8001};
    src2Sel = 4'd3; step(); check("R3 u16", immData, 64'h8001); check("R3 vld", immVld, 1);
    src2Sel = 4'd4; step(); check("R3 s16", immData, 64'hFFFF_FFFF_FFFF_8001);
    src2Sel = 4'd5; step(); check("R3 u16hi", immData, 64'h8001_0000);
    src2Sel = 4'd6; step(); check("R3 s16hi", immData, 64'hFFFF_FFFF_8001_0000);
    insnWord = {16'h0000, 16'h1234};
    src2Sel = 4'd4; step(); check("R3 s16 pos", immData, 64'h1234);
    src2Sel = 4'd6; step(); check("R3 s16hi pos", immData, 64'h1234_0000);
  endtask

  task automatic testBranchImm();
    clearIn();
    insnWord = {6'h12, 24'hABCDEF, 2'b11};
    src2Sel = 4'd7; step(); check("R4 long", immData, 64'h2AF_37BC);
    insnWord = {6'h3F, 10'h3FF, 14'h2345, 2'b11};
    src2Sel = 4'd8; step(); check("R4 cond", immData, 64'h8D14);
    src2Sel = 4'd9; step(); check("R4 disp", immData, 64'h8D14);
  endtask

  task automatic testMiscImm();
    clearIn();
    src2Sel = 4'd10; step(); check("R5 minus1", immData, 64'hFFFF_FFFF_FFFF_FFFF);
    insnWord = fmt(5'd0, 5'd0, 5'h13, 11'b000_0000_0010);
    src2Sel = 4'd11; step(); check("R5 sh6", immData, 64'h33);
    src2Sel = 4'd12; step(); check("R5 sh5", immData, 64'h13);
  endtask

  task automatic testSpr2();
    clearIn();
    src2Sel = 4'd2;
    insnWord = fmt(5'd1, 5'd2, 5'd3, 11'b100_0000_0000);
    step();
    check("R6 spr2 vld", sprRd2Vld, 1); check("R6 ctr", sprRd2Num, 9);
    check("R6 imm off", immVld, 0); check("R6 rd2 off", rdReg2Vld, 0);
    insnWord = fmt(5'd1, 5'd2, 5'd3, 11'b000_0000_0000);
    step();
    check("R6 lr", sprRd2Num, 8);
  endtask

  task automatic testSpr1();
    clearIn();
    isCondBranch = 1'b1;
    insnWord = 32'h0000_0000;
    step();
    check("R7 bc vld", sprRd1Vld, 1); check("R7 bc ctr", sprRd1Num, 9);
    insnWord = 32'h0080_0000;
    step();
    check("R7 bc bit8 set", sprRd1Vld, 0);
    isCondBranch = 1'b0; isSprMove = 1'b1;
    insnWord = {11'd0, 10'h2A5, 11'd0};
    step();
    check("R7 move vld", sprRd1Vld, 1); check("R7 move num", sprRd1Num, 10'h2A5);
  endtask

  task automatic testDest();
    clearIn();
    insnWord = fmt(5'd17, 5'd12, 5'd4, 11'd0);
    dstSel = 2'd1; step();
    check("R8 rt vld", wrRegVld, 1); check("R8 rt idx", wrRegIdx, 17);
    dstSel = 2'd2; step();
    check("R8 ra idx", wrRegIdx, 12); check("R8 ra spr", wrSprVld, 0);
    insnWord = {11'd0, 10'h321, 11'd0};
    dstSel = 2'd3; step();
    check("R8 spr vld", wrSprVld, 1); check("R8 spr gpr", wrRegVld, 0);
    check("R8 spr num", wrSprNum, 10'h321);
    dstSel = 2'd0; step();
    check("R8 none gpr", wrRegVld, 0); check("R8 none spr", wrSprVld, 0);
  endtask

  task automatic testRecord();
    clearIn();
    insnWord = 32'h0000_0401;
    recSel = 2'd0; step();
    check("R9 none", recBit, 0); check("R9 vld", recVld, 1);
    check("R9 oe", ovfBit, 1); check("R9 oe vld", ovfVld, 1);
    recSel = 2'd1; insnWord = 32'h0; step();
    check("R9 one", recBit, 1); check("R9 oe clear", ovfBit, 0);
    recSel = 2'd2; insnWord = 32'h1; step(); check("R9 rc set", recBit, 1);
    insnWord = 32'h0; step(); check("R9 rc clear", recBit, 0);
    recSel = 2'd3; insnWord = 32'h1; step(); check("R9 rsvd", recBit, 0);
  endtask

  task automatic testLinkIllegal();
    clearIn();
    insnWord = 32'h1;
    hasLink = 1'b1; step(); check("R10 link set", linkBit, 1);
    hasLink = 1'b0; step(); check("R10 link off", linkBit, 0);
    src2Sel = 4'd13; insnWord = 32'hFFFF_FFFF; step();
    check("R10 illegal", illegal, 1); check("R10 illegal imm", immVld, 0);
    src2Sel = 4'd15; step(); check("R10 illegal 15", illegal, 1);
    src2Sel = 4'd3; step(); check("R10 legal", illegal, 0);
  endtask

  task automatic testLatency();
    clearIn();
    src2Sel = 4'd3; insnWord = 32'h0000_00AA;
    step();
    insnWord = 32'h0000_0055;
    #1;
    check("R11 hold before edge", immData, 64'hAA);
    step();
    check("R11 after edge", immData, 64'h55);
  endtask

  initial begin
    testReset();
    testGprPorts();
    testRaz();
    testImm();
    testBranchImm();
    testMiscImm();
    testSpr2();
    testSpr1();
    testDest();
    testRecord();
    testLinkIllegal();
    testLatency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule